// File: doc/BRIEF.md
# Receiver Error Flag Aggregator

This block gathers the error indications of a digital audio receiver into one error output. The sources are loss of lock, parity, biphase coding, frame length and a change in the decoded status word. A programmable hold time stretches the output after the last error goes away, so that a slow controller or a mute circuit cannot miss a short error burst. The hold time is counted in frame periods.

Beside the merged output the block keeps sticky per-error bits that a read of the second status register clears. It also runs the status-change detector. Once per frame, at the frame strobe, the detector compares a 6-bit status word with its value at the previous strobe. A change raises a flag that stays up until the first status register is read. In serial (register) mode, two report enables select which errors reach the output. In parallel (pin) mode, the output is a fixed merge of the receive errors.

Top module: `rxerr_merge`

## Requirements
- R1: After a synchronous reset, `err_out`, `stc_flag` and all five `sticky` bits are 0.
- R2: The `sticky` vector (bit 0 parity, bit 1 biphase, bit 2 frame length, bit 3 validity, bit 4 unlock) sets a bit on the clock edge after its source is seen high. Each set bit holds until the edge at which `rd_stat2` is sampled high. A source high on that same edge keeps the bit set.
- R3: `stc_flag` can rise only on an edge that samples `fs_tick` high. It rises when the 6-bit `stat_word` differs from the value it had at the previous `fs_tick`.
- R4: Status changes seen at the first 192 frame strobes after reset do not set `stc_flag`. `stc_flag` clears on the edge that samples `rd_stat1` high, unless a change is detected on that same edge.
- R5: In serial mode (`serial_mode`=1), the error factors are: unlock; parity, biphase and frame-length pulses when `par_report_en`=1; and `stc_flag` when `stc_report_en`=1.
- R6: In parallel mode (`serial_mode`=0), the error factors are unlock, parity, biphase and frame length, whatever the report enables say. `stc_flag` never contributes.
- R7: Unlock is always a factor and cannot be masked.
- R8: `err_out` goes high on the edge after any factor is seen. After the last active cycle it stays high until the edge that samples the N-th `fs_tick`, where N = 512 << `hold_sel` (00=512, 01=1024, 10=2048, 11=4096).
- R9: A factor that is seen during the hold restarts the hold from its full length.
- R10: For a status change the hold starts when `rd_stat1` clears `stc_flag`, not when the change occurs.
- R11: While `pll_off` is sampled high, `err_out` is low on the following edge and any pending hold is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fs_tick | input | 1 | One-cycle strobe per frame |
| par_err | input | 1 | Parity error pulse |
| bip_err | input | 1 | Biphase error pulse |
| len_err | input | 1 | Frame-length error pulse |
| val_flag | input | 1 | Validity flag pulse |
| unlock | input | 1 | PLL unlock level |
| stat_word | input | 6 | Status word compared once per frame |
| par_report_en | input | 1 | Serial mode: report parity, biphase and frame-length errors |
| stc_report_en | input | 1 | Serial mode: report status change |
| hold_sel | input | 2 | Hold length code |
| serial_mode | input | 1 | 1 = serial mode, 0 = parallel mode |
| pll_off | input | 1 | PLL powered down; forces the output low |
| rd_stat1 | input | 1 | Read strobe of status register 1 |
| rd_stat2 | input | 1 | Read strobe of status register 2 |
| err_out | output | 1 | Merged, held error output |
| stc_flag | output | 1 | Status-change flag |
| sticky | output | 5 | Sticky error bits, read-to-clear |

## Verification
The bench targets the exact drop edge of the hold: it checks that the output is still high after N-1 frame strobes and low after N. A design that is off by one strobe, or that counts clock cycles instead of frames, fails this check. It places a fresh error in the middle of a hold to catch a design that keeps counting down instead of restarting. It checks the 192-frame blanking window on both sides, which exposes a design that flags the first comparison against the reset value or that blanks one frame too long. It drives reads on the same edge as new events, so a design in which the clear wins loses the event. It toggles the mode and report enables to catch a design that masks unlock or lets the status change through in parallel mode.

// File: rtl/rxerr_pkg.sv
package rxerr_pkg;

    typedef struct packed {
        logic unlock;
        logic val;
        logic len;
        logic bip;
        logic par;
    } rx_flags_t;

    localparam int FLAG_N = $bits(rx_flags_t);

    function automatic int hold_frames(input int base, input logic [1:0] sel);
        return base << sel;
    endfunction

endpackage

// File: rtl/rxerr_sticky.sv
module rxerr_sticky #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic [N-1:0] ev,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst) bit_q <= 1'b0;
            else     bit_q <= (bit_q & ~clr) | ev[i];
        end
        assign q[i] = bit_q;
    end
endmodule

// File: rtl/rxerr_stc.sv
module rxerr_stc #(
    parameter int WORD_W       = 6,
    parameter int BLOCK_FRAMES = 192
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fs_tick,
    input  logic [WORD_W-1:0] word,
    input  logic              rd_clr,
    output logic              flag
);
    localparam int BW = $clog2(BLOCK_FRAMES + 1);

    logic [WORD_W-1:0] prev_q;
    logic [BW-1:0]     seen_q;
    logic              armed;
    logic              hit;
    logic              flag_q;

    assign armed = (seen_q == BW'(BLOCK_FRAMES));
    assign hit   = fs_tick && armed && (word != prev_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            seen_q <= '0;
            flag_q <= 1'b0;
        end else begin
            if (fs_tick) begin
                prev_q <= word;
                if (!armed) seen_q <= seen_q + BW'(1);
            end
            flag_q <= (flag_q & ~rd_clr) | hit;
        end
    end

    assign flag = flag_q;
endmodule

// File: rtl/rxerr_hold.sv
module rxerr_hold #(
    parameter int HOLD_BASE = 512
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pll_off,
    input  logic       active,
    input  logic       fs_tick,
    input  logic [1:0] sel,
    output logic       err
);
    import rxerr_pkg::*;
    localparam int CW = $clog2(HOLD_BASE * 8 + 1);

    logic [CW-1:0] cnt_q, cnt_n;
    logic          err_q;

    always_comb begin
        cnt_n = cnt_q;
        if (pll_off)                       cnt_n = '0;
        else if (active)                   cnt_n = CW'(hold_frames(HOLD_BASE, sel));
        else if (fs_tick && cnt_q != '0)   cnt_n = cnt_q - CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            err_q <= 1'b0;
        end else begin
            cnt_q <= cnt_n;
            err_q <= !pll_off && (active || cnt_n != '0);
        end
    end

    assign err = err_q;
endmodule

// File: rtl/rxerr_merge.sv
module rxerr_merge #(
    parameter int HOLD_BASE    = 512,
    parameter int BLOCK_FRAMES = 192,
    parameter int WORD_W       = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fs_tick,
    input  logic              par_err,
    input  logic              bip_err,
    input  logic              len_err,
    input  logic              val_flag,
    input  logic              unlock,
    input  logic [WORD_W-1:0] stat_word,
    input  logic              par_report_en,
    input  logic              stc_report_en,
    input  logic [1:0]        hold_sel,
    input  logic              serial_mode,
    input  logic              pll_off,
    input  logic              rd_stat1,
    input  logic              rd_stat2,
    output logic              err_out,
    output logic              stc_flag,
    output logic [4:0]        sticky
);
    import rxerr_pkg::*;

    rx_flags_t ev;
    logic      rx_err_any;
    logic      rx_err_on;
    logic      stc_on;
    logic      active;

    always_comb begin
        ev.par    = par_err;
        ev.bip    = bip_err;
        ev.len    = len_err;
        ev.val    = val_flag;
        ev.unlock = unlock;
    end

    rxerr_sticky #(.N(FLAG_N)) u_sticky (
        .clk (clk),
        .rst (rst),
        .clr (rd_stat2),
        .ev  (ev),
        .q   (sticky)
    );

    rxerr_stc #(.WORD_W(WORD_W), .BLOCK_FRAMES(BLOCK_FRAMES)) u_stc (
        .clk     (clk),
        .rst     (rst),
        .fs_tick (fs_tick),
        .word    (stat_word),
        .rd_clr  (rd_stat1),
        .flag    (stc_flag)
    );

    assign rx_err_any = ev.par | ev.bip | ev.len;
    assign rx_err_on  = rx_err_any & (~serial_mode | par_report_en);
    assign stc_on     = serial_mode & stc_report_en & stc_flag;
    assign active     = ev.unlock | rx_err_on | stc_on;

    rxerr_hold #(.HOLD_BASE(HOLD_BASE)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .pll_off (pll_off),
        .active  (active),
        .fs_tick (fs_tick),
        .sel     (hold_sel),
        .err     (err_out)
    );
endmodule

// File: rtl/rxerr_merge_chk.sv
module rxerr_merge_chk #(
    parameter int WORD_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              fs_tick,
    input logic              par_err,
    input logic              unlock,
    input logic              pll_off,
    input logic              rd_stat1,
    input logic              rd_stat2,
    input logic              err_out,
    input logic              stc_flag,
    input logic [4:0]        sticky
);
    assert_reset_R1: assert property (@(posedge clk) rst |=> (!err_out && !stc_flag && sticky == 5'b0));

    assert_par_sets_R2: assert property (@(posedge clk) disable iff (rst) par_err |=> sticky[0]);

    assert_sticky_keep_R2: assert property (@(posedge clk) disable iff (rst)
        !rd_stat2 |=> (($past(sticky) & ~sticky) == 5'b0));

    assert_stc_on_tick_R3: assert property (@(posedge clk) disable iff (rst)
        !fs_tick |=> !$rose(stc_flag));

    assert_stc_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_stat1 && !fs_tick) |=> !stc_flag);

    assert_unlock_R7: assert property (@(posedge clk) disable iff (rst)
        (unlock && !pll_off) |=> err_out);

    assert_pll_off_R11: assert property (@(posedge clk) disable iff (rst)
        pll_off |=> !err_out);
endmodule

bind rxerr_merge rxerr_merge_chk #(.WORD_W(WORD_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .fs_tick  (fs_tick),
    .par_err  (par_err),
    .unlock   (unlock),
    .pll_off  (pll_off),
    .rd_stat1 (rd_stat1),
    .rd_stat2 (rd_stat2),
    .err_out  (err_out),
    .stc_flag (stc_flag),
    .sticky   (sticky)
);

// File: tb/rxerr_merge_bench.sv
module rxerr_merge_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fs_tick = 1'b0;
    logic       par_err = 0, bip_err = 0, len_err = 0, val_flag = 0, unlock = 0;
    logic [5:0] stat_word = '0;
    logic       par_report_en = 1, stc_report_en = 1;
    logic [1:0] hold_sel = 2'b00;
    logic       serial_mode = 1, pll_off = 0, rd_stat1 = 0, rd_stat2 = 0;
    logic       err_out, stc_flag;
    logic [4:0] sticky;

    int checks = 0;
    int errors = 0;
    int phase = 0;
    int cycles = 0;
    string cur_req = "R8";

    // reference state
    logic [4:0]  m_sticky;
    logic        m_stc, m_err;
    logic [5:0]  m_prev;
    int          m_seen, m_cnt;

    always #2.5 clk = ~clk;

    rxerr_merge u_rxerr_merge (.*);

    function automatic int frames_for(input logic [1:0] s);
        return 512 << s;
    endfunction

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0d expected %0d at cycle %0d", req, got, exp, cycles);
        end
    endtask

    task automatic model_update();
        logic act, set, stc_old;
        stc_old = m_stc;
        if (rst) begin
            m_sticky = '0; m_stc = 0; m_err = 0; m_prev = '0; m_seen = 0; m_cnt = 0;
            return;
        end
        m_sticky = (m_sticky & ~{5{rd_stat2}}) | {unlock, val_flag, len_err, bip_err, par_err};
        set = 0;
        if (fs_tick) begin
            if (m_seen >= 192 && stat_word != m_prev) set = 1;
            m_prev = stat_word;
            if (m_seen < 192) m_seen++;
        end
        m_stc = (m_stc & !rd_stat1) | set;
        act = unlock || ((par_err || bip_err || len_err) && (!serial_mode || par_report_en))
              || (serial_mode && stc_report_en && stc_old);
        if (pll_off)                   m_cnt = 0;
        else if (act)                  m_cnt = frames_for(hold_sel);
        else if (fs_tick && m_cnt > 0) m_cnt--;
        m_err = !pll_off && (act || m_cnt != 0);
    endtask

    // one clock: inputs were set at negedge; returns whether fs_tick was sampled
    task automatic step(output bit ticked);
        fs_tick = (phase == 3);
        phase = (phase + 1) % 4;
        ticked = fs_tick;
        @(posedge clk);
        model_update();
        @(negedge clk);
        cycles++;
        if (!rst) begin
            check(cur_req, err_out, m_err);
            check("R3/R4 stc_flag", stc_flag, m_stc);
            check("R2 sticky", sticky, m_sticky);
        end
        par_err = 0; bip_err = 0; len_err = 0; val_flag = 0; rd_stat1 = 0; rd_stat2 = 0;
    endtask

    task automatic run(input int n);
        bit t;
        for (int i = 0; i < n; i++) step(t);
    endtask

    task automatic wait_ticks(input int n);
        int k;
        bit t;
        k = 0;
        while (k < n) begin step(t); if (t) k++; end
    endtask

    task automatic do_reset();
        rst = 1; run(3); rst = 0;
    endtask

    initial begin
        bit t;
        void'($urandom(32'd7041));
        @(negedge clk);
        do_reset();
        run(1);
        check("R1 err after reset", err_out, 0);
        check("R1 stc after reset", stc_flag, 0);
        check("R1 sticky after reset", sticky, 0);

        // R2: set, hold, read clear, coincident read keeps bit
        cur_req = "R2";
        bip_err = 1; run(1);
        check("R2 biphase bit set", sticky[1], 1);
        run(3);
        check("R2 biphase bit held", sticky[1], 1);
        rd_stat2 = 1; val_flag = 1; run(1);
        check("R2 validity survives coincident read", sticky[3], 1);
        check("R2 biphase cleared by read", sticky[1], 0);
        rd_stat2 = 1; run(1);
        check("R2 all clear", sticky, 0);

        // R3/R4 blanking: change word on every frame during the first block
        cur_req = "R10";
        do_reset();
        for (int f = 0; f < 191; f++) begin stat_word = 6'(f); wait_ticks(1); end
        stat_word = 6'h2a; wait_ticks(1);
        check("R4 no flag inside first block", stc_flag, 0);
        stat_word = 6'h15; wait_ticks(1);
        check("R3 flag after block on change", stc_flag, 1);
        run(2);
        check("R10 error held while flag set", err_out, 1);
        rd_stat1 = 1; run(1);
        check("R4 flag cleared by read", stc_flag, 0);
        hold_sel = 2'b00;
        wait_ticks(511);
        check("R10 hold runs from read", err_out, 1);
        wait_ticks(1);
        check("R10 hold ends after 512 frames", err_out, 0);

        // R8 exact hold with code 00 and R9 restart
        cur_req = "R8";
        par_err = 1; run(1);
        wait_ticks(300);
        cur_req = "R9";
        len_err = 1; run(1);
        wait_ticks(511);
        check("R9 restarted hold still high", err_out, 1);
        wait_ticks(1);
        check("R9 drop after full restart", err_out, 0);

        // R8 with code 11
        cur_req = "R8";
        hold_sel = 2'b11; unlock = 1; run(2); unlock = 0; run(1);
        wait_ticks(4095);
        check("R8 4096 hold high", err_out, 1);
        wait_ticks(1);
        check("R8 4096 hold low", err_out, 0);
        hold_sel = 2'b01;

        // R5 masking in serial mode, R7 unlock unmasked
        cur_req = "R5";
        par_report_en = 0; stc_report_en = 0;
        par_err = 1; bip_err = 1; run(2);
        check("R5 masked parity ignored", err_out, 0);
        cur_req = "R7";
        unlock = 1; run(1); unlock = 0;
        check("R7 unlock passes mask", err_out, 1);
        pll_off = 1; run(1); pll_off = 0;
        cur_req = "R11";
        check("R11 pll off clears", err_out, 0);
        run(2);
        check("R11 hold discarded", err_out, 0);

        // R6 parallel mode ignores enables, excludes stc
        cur_req = "R6";
        serial_mode = 0; stc_report_en = 1;
        stat_word = 6'h01; wait_ticks(1); stat_word = 6'h02; wait_ticks(1);
        check("R6 stc flag set but not reported", err_out, 0);
        len_err = 1; run(1);
        check("R6 frame length reported despite mask", err_out, 1);
        pll_off = 1; run(1); pll_off = 0; rd_stat1 = 1; run(1);

        // random phase
        cur_req = "R5/R6/R8 random";
        for (int i = 0; i < 20000; i++) begin
            par_err  = ($urandom % 400) == 0;
            bip_err  = ($urandom % 600) == 0;
            len_err  = ($urandom % 600) == 0;
            val_flag = ($urandom % 50) == 0;
            rd_stat1 = ($urandom % 40) == 0;
            rd_stat2 = ($urandom % 40) == 0;
            if (($urandom % 300) == 0) unlock = ~unlock;
            if (($urandom % 500) == 0) pll_off = ~pll_off;
            if (($urandom % 700) == 0) serial_mode = ~serial_mode;
            if (($urandom % 700) == 0) par_report_en = ~par_report_en;
            if (($urandom % 700) == 0) stc_report_en = ~stc_report_en;
            if (($urandom % 900) == 0) hold_sel = 2'($urandom);
            if (($urandom % 30) == 0) stat_word = 6'($urandom);
            step(t);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule